// File: doc/BRIEF.md
# Link Wake and Reset Controller

This block sits beside the link layer of a serial-bus controller and decides three things: whether the link is in its low-power state, when the embedded CPU should be woken, and whether the CPU may be held in reset. Software drives it through a small register port with a write strobe, a two-bit address and eight data bits, and reads it back through a separate combinational read port. Hardware event inputs arrive as levels or single-cycle pulses: a received link-on packet, a PHY interrupt, a host-priority-high interrupt and the PHY's link-control bit.

A software reset request for the CPU is honoured only while a sticky reset-block flag is clear. Hardware sets that flag on every 0-to-1 edge of the link-on output, the PHY interrupt or the host-priority-high interrupt, so a wake-type event can never be lost to a reset that software issued at the same time. The active-low external reset pin bypasses the flag completely. A separate active-low pin turns off the output enables of all external interfaces, while the low-power status output stays driven.

Top module: `link_wake_rst_ctrl`

## Requirements
- R1: Bit 0 of the control register (address 0) is the low-power bit. Writing 1 sets it once the power-up wait has elapsed. Writing 0 clears it at any time. The `lp_status` output shows it in the cycle after the write.
- R2: For the first `(CLK_HZ/1000000)*WAIT_US` clock cycles after reset, a write that sets the low-power bit is ignored. Bit 1 of the status register (address 3) reads 1 once that wait is over.
- R3: When the low-power bit is 0, `phy_lctrl` is 1 and `linkon_pkt` is high at a clock edge, `linkon` becomes 1 after that edge and stays 1 until it is cleared.
- R4: `linkon` is cleared after any edge at which the low-power bit is 1 or `phy_lctrl` is 0. The clear takes priority over a packet in the same cycle.
- R5: Bit 0 of the status register (address 3) always equals the `linkon` output.
- R6: The reset-block flag (address 1, bit 0) is set after any edge at which `linkon`, `phy_int` or `hp_int` is 1 and was 0 at the previous edge.
- R7: Writing address 1 with data bit 0 equal to 0 clears the reset-block flag. A hardware set in the same cycle wins.
- R8: Writing the control register with bit 2 set raises `cpu_rst` only if the reset-block flag is 0. If the flag is 1, the write leaves that bit unchanged. Writing bit 2 as 0 clears it. Bit 2 reads back at address 0.
- R9: While `ext_rst_n` is 0, `cpu_rst` is 1 whatever the state of the flag or the register bits.
- R10: With the wake-enable bit (address 0, bit 1) set, a rising `linkon` latches event bit 0 and a rising `phy_int` latches event bit 1 (address 2). `wake_req` is the OR of both bits and holds until software writes 1 to the matching bit at address 2. A new event in the same cycle wins.
- R11: While `if_dis_n` is 0, every bit of `if_oe` is 0, and `lp_status` still shows the low-power bit.
- R12: After a synchronous reset, all register bits, `linkon`, `wake_req` and the power-up timer are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Combinational read data |
| ext_rst_n | input | 1 | External CPU reset pin, active low |
| linkon_pkt | input | 1 | Pulse: link-on packet received |
| phy_int | input | 1 | PHY interrupt level |
| hp_int | input | 1 | Host-priority-high interrupt level |
| phy_lctrl | input | 1 | PHY link-control bit |
| if_dis_n | input | 1 | Interface disable, active low |
| cpu_rst | output | 1 | CPU reset, active high |
| wake_req | output | 1 | Wake request level to the CPU |
| linkon | output | 1 | Link-on indication |
| lp_status | output | 1 | Low-power status, never disabled |
| if_oe | output | N_IF | Output enables of external interfaces |

## Verification
The embedded assertions check the following on every cycle: a blocked software reset never takes effect, the external pin always forces reset, an early low-power write never lands, a clear condition always drops `linkon`, every rising event sets the reset-block flag, and a latched wake event holds until software clears it. Other behaviour needs the bench's scenarios to show it: the exact cycle the power-up wait ends, the priority of a hardware set over a software clear in the same cycle, the output enables going off while `lp_status` stays driven, and the read-back of each register. A reference model in the bench tracks these under random register writes and event toggling.

// File: rtl/lwr_pkg.sv
`timescale 1ns/1ps
// Shared register addresses and field positions for the wake/reset controller.
// Assumes a two-bit address space with four registers.
package lwr_pkg;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] A_RSTBLK = 2'd1;
    localparam logic [ADDR_W-1:0] A_EVENT  = 2'd2;
    localparam logic [ADDR_W-1:0] A_STAT   = 2'd3;
    // control register fields
    localparam int B_LP    = 0;
    localparam int B_WAKE  = 1;
    localparam int B_SWRST = 2;
    // event register fields
    localparam int N_EV      = 2;
    localparam int B_EV_LINK = 0;
    localparam int B_EV_PHY  = 1;
    // status register fields
    localparam int B_ST_LINK = 0;
    localparam int B_ST_RDY  = 1;
endpackage

// File: rtl/lwr_pwrup_timer.sv
`timescale 1ns/1ps
// Power-up wait timer: raises ready after WAIT_US microseconds of clocks
// following reset and then holds it. Assumes CLK_HZ is a multiple of 1 MHz.
module lwr_pwrup_timer #(
    parameter int unsigned CLK_HZ  = 50_000_000,
    parameter int unsigned WAIT_US = 2000
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready
);
    localparam int unsigned RAW   = (CLK_HZ / 1_000_000) * WAIT_US;
    localparam int unsigned LIMIT = (RAW < 1) ? 1 : RAW;
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_q;

    // count clock cycles until the wait has elapsed, then stop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ready <= 1'b0;
        end else if (!ready) begin
            if (cnt_q == CNT_W'(LIMIT - 1)) ready <= 1'b1;
            else                            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready); // R2
endmodule

// File: rtl/lwr_linkon.sv
`timescale 1ns/1ps
// Link-on tracker: sets on a received link-on packet while out of low power,
// clears when low power is active or the PHY link-control bit is zero.
// Assumes linkon_pkt is already synchronous to clk.
module lwr_linkon (
    input  logic clk,
    input  logic rst_n,
    input  logic lp,
    input  logic pkt,
    input  logic lctrl,
    output logic linkon
);
    // clear has priority over a set in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)               linkon <= 1'b0;
        else if (lp || !lctrl)    linkon <= 1'b0;
        else if (pkt)             linkon <= 1'b1;
    end

    AST_LINKON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (lp || !lctrl) |=> !linkon); // R4
    AST_LINKON_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!lp && lctrl && pkt) |=> linkon); // R3
endmodule

// File: rtl/lwr_event_ctl.sv
`timescale 1ns/1ps
// Event logic: edge-detects the wake-type sources, keeps the sticky
// reset-block flag and the per-source wake event latches.
// Assumes the sources are synchronous levels; hardware sets beat software clears.
module lwr_event_ctl #(
    parameter int N_EV = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            linkon,
    input  logic            phy_int,
    input  logic            hp_int,
    input  logic            wake_en,
    input  logic            blk_clr,
    input  logic [N_EV-1:0] ev_clr,
    output logic            rst_blk,
    output logic [N_EV-1:0] ev
);
    localparam int N_SRC = 3;

    logic [N_SRC-1:0] src, src_q, rise;
    logic [N_EV-1:0]  ev_set;

    assign src  = {hp_int, phy_int, linkon};
    assign rise = src & ~src_q;

    // remember the previous level of each source
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src;
    end

    // sticky reset-block flag: any rising source sets it, software clears it
    always_ff @(posedge clk) begin
        if (!rst_n)        rst_blk <= 1'b0;
        else if (|rise)    rst_blk <= 1'b1;
        else if (blk_clr)  rst_blk <= 1'b0;
    end

    // wake events come from the link-on and PHY-interrupt edges only
    assign ev_set = {rise[1], rise[0]} & {N_EV{wake_en}};

    for (genvar i = 0; i < N_EV; i++) begin : g_ev
        // latch one wake event until software writes 1 to clear it
        always_ff @(posedge clk) begin
            if (!rst_n)         ev[i] <= 1'b0;
            else if (ev_set[i]) ev[i] <= 1'b1;
            else if (ev_clr[i]) ev[i] <= 1'b0;
        end

        AST_WAKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (ev[i] && !ev_clr[i]) |=> ev[i]); // R10
    end

    AST_RSTBLK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> rst_blk); // R6
endmodule

// File: rtl/link_wake_rst_ctrl.sv
`timescale 1ns/1ps
// Link wake and reset controller top: register port, low-power bit with a
// power-up lockout, CPU reset gating through the reset-block flag, wake
// request and interface output enables. Assumes all inputs are synchronous.
module link_wake_rst_ctrl
    import lwr_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 50_000_000,
    parameter int unsigned WAIT_US = 2000,
    parameter int          DATA_W  = 8,
    parameter int          N_IF    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ext_rst_n,
    input  logic              linkon_pkt,
    input  logic              phy_int,
    input  logic              hp_int,
    input  logic              phy_lctrl,
    input  logic              if_dis_n,
    output logic              cpu_rst,
    output logic              wake_req,
    output logic              linkon,
    output logic              lp_status,
    output logic [N_IF-1:0]   if_oe
);
    logic            ready;
    logic            lp_q, wake_en_q, swrst_q;
    logic            rst_blk;
    logic [N_EV-1:0] ev, ev_clr;
    logic            wr_ctrl, blk_clr;
    logic            unused_wdata;

    assign unused_wdata = ^wr_data[DATA_W-1:3];

    lwr_pwrup_timer #(.CLK_HZ(CLK_HZ), .WAIT_US(WAIT_US)) u_timer (
        .clk(clk), .rst_n(rst_n), .ready(ready));

    lwr_linkon u_linkon (
        .clk(clk), .rst_n(rst_n), .lp(lp_q), .pkt(linkon_pkt),
        .lctrl(phy_lctrl), .linkon(linkon));

    lwr_event_ctl #(.N_EV(N_EV)) u_events (
        .clk(clk), .rst_n(rst_n), .linkon(linkon), .phy_int(phy_int),
        .hp_int(hp_int), .wake_en(wake_en_q), .blk_clr(blk_clr),
        .ev_clr(ev_clr), .rst_blk(rst_blk), .ev(ev));

    // write decode for each register
    assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
    assign blk_clr = wr_en && (wr_addr == A_RSTBLK) && !wr_data[0];
    assign ev_clr  = (wr_en && (wr_addr == A_EVENT)) ? wr_data[N_EV-1:0] : '0;

    // control register: low-power set needs ready, reset set needs flag clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lp_q      <= 1'b0;
            wake_en_q <= 1'b0;
            swrst_q   <= 1'b0;
        end else if (wr_ctrl) begin
            lp_q      <= wr_data[B_LP] & (ready | lp_q);
            wake_en_q <= wr_data[B_WAKE];
            swrst_q   <= wr_data[B_SWRST] & (~rst_blk | swrst_q);
        end
    end

    // outputs: the pin reset bypasses the flag, enables follow the disable pin
    assign cpu_rst   = swrst_q | ~ext_rst_n;
    assign wake_req  = |ev;
    assign lp_status = lp_q;
    for (genvar k = 0; k < N_IF; k++) begin : g_oe
        assign if_oe[k] = if_dis_n;
    end

    // combinational read-back mux
    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_CTRL: begin
                rd_data[B_LP]    = lp_q;
                rd_data[B_WAKE]  = wake_en_q;
                rd_data[B_SWRST] = swrst_q;
            end
            A_RSTBLK: rd_data[0] = rst_blk;
            A_EVENT:  rd_data[N_EV-1:0] = ev;
            default: begin
                rd_data[B_ST_LINK] = linkon;
                rd_data[B_ST_RDY]  = ready;
            end
        endcase
    end

    AST_SWRST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wr_data[B_SWRST] && rst_blk && !swrst_q) |=> !cpu_rst || !ext_rst_n); // R8
    AST_PIN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_rst_n |-> cpu_rst); // R9
    AST_LP_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !ready && !lp_q) |=> !lp_status); // R2
    AST_LP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(lp_status)); // R1
endmodule

// File: tb/link_wake_rst_ctrl_tb.sv
`timescale 1ns/1ps
module link_wake_rst_ctrl_tb_top;
    localparam int N_IF  = 4;
    localparam int LIMIT = 40; // CLK_HZ 1 MHz, WAIT_US 40

    logic       clk = 1'b0;
    logic       rst_n, wr_en, ext_rst_n, linkon_pkt, phy_int, hp_int, phy_lctrl, if_dis_n;
    logic [1:0] wr_addr, rd_addr;
    logic [7:0] wr_data, rd_data;
    logic       cpu_rst, wake_req, linkon, lp_status;
    logic [N_IF-1:0] if_oe;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    link_wake_rst_ctrl #(.CLK_HZ(1_000_000), .WAIT_US(40), .DATA_W(8), .N_IF(N_IF)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ext_rst_n(ext_rst_n),
        .linkon_pkt(linkon_pkt), .phy_int(phy_int), .hp_int(hp_int),
        .phy_lctrl(phy_lctrl), .if_dis_n(if_dis_n), .cpu_rst(cpu_rst),
        .wake_req(wake_req), .linkon(linkon), .lp_status(lp_status), .if_oe(if_oe));

    // reference model state, built from the requirements
    int   m_cnt;
    logic m_rdy, m_lp, m_wake, m_sw, m_link, m_blk, m_pl, m_pp, m_ph;
    logic [1:0] m_ev;

    always @(posedge clk) begin : model
        logic lr, pr, hr, n_link, n_blk, n_lp, n_wake, n_sw;
        logic [1:0] n_ev;
        if (!rst_n) begin
            m_cnt = 0; m_rdy = 0; m_lp = 0; m_wake = 0; m_sw = 0; m_link = 0;
            m_blk = 0; m_pl = 0; m_pp = 0; m_ph = 0; m_ev = 0;
        end else begin
            lr = m_link & ~m_pl; pr = phy_int & ~m_pp; hr = hp_int & ~m_ph;
            n_link = (m_lp || !phy_lctrl) ? 1'b0 : (linkon_pkt ? 1'b1 : m_link);
            n_blk  = (lr | pr | hr) ? 1'b1 :
                     (wr_en && wr_addr == 2'd1 && !wr_data[0]) ? 1'b0 : m_blk;
            n_lp = m_lp; n_wake = m_wake; n_sw = m_sw;
            if (wr_en && wr_addr == 2'd0) begin
                n_lp   = wr_data[0] ? (m_rdy ? 1'b1 : m_lp) : 1'b0;
                n_wake = wr_data[1];
                n_sw   = wr_data[2] ? (m_blk ? m_sw : 1'b1) : 1'b0;
            end
            n_ev[0] = (m_wake && lr) ? 1'b1 : (wr_en && wr_addr == 2'd2 && wr_data[0]) ? 1'b0 : m_ev[0];
            n_ev[1] = (m_wake && pr) ? 1'b1 : (wr_en && wr_addr == 2'd2 && wr_data[1]) ? 1'b0 : m_ev[1];
            if (!m_rdy) begin
                if (m_cnt == LIMIT - 1) m_rdy = 1'b1;
                else                    m_cnt = m_cnt + 1;
            end
            m_pl = m_link; m_pp = phy_int; m_ph = hp_int;
            m_link = n_link; m_blk = n_blk; m_lp = n_lp; m_wake = n_wake; m_sw = n_sw; m_ev = n_ev;
        end
    end

    function automatic logic [7:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0:    return {5'd0, m_sw, m_wake, m_lp};
            2'd1:    return {7'd0, m_blk};
            2'd2:    return {6'd0, m_ev};
            default: return {6'd0, m_rdy, m_link};
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        rd_addr = 2'($urandom);
        #1;
        chk("R8 R9 cpu_rst", {31'd0, cpu_rst}, {31'd0, m_sw | ~ext_rst_n});
        chk("R3 R4 linkon", {31'd0, linkon}, {31'd0, m_link});
        chk("R10 wake_req", {31'd0, wake_req}, {31'd0, |m_ev});
        chk("R1 lp_status", {31'd0, lp_status}, {31'd0, m_lp});
        chk("R11 if_oe", {28'd0, if_oe}, {28'd0, {N_IF{if_dis_n}}});
        chk("R5 R6 R7 rd_data", {24'd0, rd_data}, {24'd0, exp_rd(rd_addr)});
    endtask

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cycle();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    initial begin : watchdog
        #(20 * 150000);
        fails++;
        $display("FAIL R12 watchdog actual=timeout expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        void'($urandom(32'd4711));
        rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
        ext_rst_n = 1; linkon_pkt = 0; phy_int = 0; hp_int = 0; phy_lctrl = 0; if_dis_n = 1;
        repeat (3) @(negedge clk);
        // R12: reset state of every register
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R12 reset rd_data", {24'd0, v}, 32'd0);
        end
        chk("R12 reset outputs", {28'd0, cpu_rst, wake_req, linkon, lp_status}, 32'd0);
        rst_n = 1;

        // R2: early low-power write is ignored
        wr(2'd0, 8'h01);
        chk("R2 early lp write", {31'd0, lp_status}, 32'd0);
        repeat (LIMIT - 4) cycle();
        rd(2'd3, v);
        chk("R2 not ready yet", {31'd0, v[1]}, 32'd0);
        repeat (4) cycle();
        rd(2'd3, v);
        chk("R2 ready", {31'd0, v[1]}, 32'd1);

        // R1: set and clear low power
        wr(2'd0, 8'h01);
        chk("R1 lp set", {31'd0, lp_status}, 32'd1);
        wr(2'd0, 8'h00);
        chk("R1 lp clear", {31'd0, lp_status}, 32'd0);

        // R3 R5 R6: link-on then flag
        phy_lctrl = 1; linkon_pkt = 1;
        cycle();
        linkon_pkt = 0;
        chk("R3 linkon set", {31'd0, linkon}, 32'd1);
        rd(2'd3, v);
        chk("R5 status mirrors linkon", {31'd0, v[0]}, 32'd1);
        cycle();
        rd(2'd1, v);
        chk("R6 flag after linkon rise", {31'd0, v[0]}, 32'd1);
        // R4: link-control low clears, even with a packet
        phy_lctrl = 0; linkon_pkt = 1;
        cycle();
        linkon_pkt = 0;
        chk("R4 linkon cleared", {31'd0, linkon}, 32'd0);
        phy_lctrl = 1;

        // R8 R7: blocked then allowed software reset
        wr(2'd0, 8'h04);
        chk("R8 blocked sw reset", {31'd0, cpu_rst}, 32'd0);
        wr(2'd1, 8'h00);
        rd(2'd1, v);
        chk("R7 flag cleared", {31'd0, v[0]}, 32'd0);
        wr(2'd0, 8'h04);
        chk("R8 sw reset taken", {31'd0, cpu_rst}, 32'd1);
        wr(2'd0, 8'h00);
        chk("R8 sw reset released", {31'd0, cpu_rst}, 32'd0);

        // R9: pin reset with the flag set
        phy_int = 1;
        cycle();
        ext_rst_n = 0;
        #1;
        chk("R9 pin reset bypasses flag", {31'd0, cpu_rst}, 32'd1);
        cycle();
        ext_rst_n = 1;

        // R7: hardware set beats software clear
        wr(2'd1, 8'h00);
        hp_int = 1;
        wr(2'd1, 8'h00);
        rd(2'd1, v);
        chk("R7 hw set wins", {31'd0, v[0]}, 32'd1);

        // R11: interfaces off, low-power status still driven
        wr(2'd0, 8'h01);
        if_dis_n = 0;
        #1;
        chk("R11 oe off", {28'd0, if_oe}, 32'd0);
        chk("R11 lp_status driven", {31'd0, lp_status}, 32'd1);
        cycle();
        if_dis_n = 1;
        wr(2'd0, 8'h00);

        // R10: wake event latch and clear
        phy_int = 0;
        wr(2'd0, 8'h02);
        phy_int = 1;
        cycle();
        chk("R10 wake raised", {31'd0, wake_req}, 32'd1);
        phy_int = 0;
        cycle();
        chk("R10 wake held", {31'd0, wake_req}, 32'd1);
        wr(2'd2, 8'h02);
        chk("R10 wake cleared", {31'd0, wake_req}, 32'd0);

        // random phase against the model
        for (int i = 0; i < 4000; i++) begin
            wr_en      = ($urandom % 5) == 0;
            wr_addr    = 2'($urandom);
            wr_data    = 8'($urandom);
            linkon_pkt = ($urandom % 8) == 0;
            if (($urandom % 16) == 0) phy_int = ~phy_int;
            if (($urandom % 16) == 0) hp_int  = ~hp_int;
            phy_lctrl  = ($urandom % 10) != 0;
            ext_rst_n  = ($urandom % 20) != 0;
            if_dis_n   = ($urandom % 10) != 0;
            rst_n      = ($urandom % 500) != 0;
            cycle();
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule